// File: doc/BRIEF.md
# Display Controller Control Register File with Set/Clear Aliases

This block holds the control and status state of a display controller. Software reaches each register at its base offset for an ordinary read-modify-write, and also at two alias offsets: one that turns on only the bits written as one, and one that turns off only the bits written as one. Single-field changes therefore need no read first and cannot race with bits that hardware updates.

The main control register carries a soft-reset bit and a clock-gate bit. Software brings the controller up with a fixed sequence: it clears soft reset and polls it, clears the clock gate, clears soft reset again, and polls until the gate reads zero. While soft reset is held, every other field drops to its default. The same register holds the run, dot-clock-mode and bus-width controls. The run readback is a status: once run is cleared, it stays high until the downstream FIFO reports empty. A second register holds the pixel packing field, a self-clearing FIFO-clear strobe, and a frame-done interrupt enable with a sticky status bit.

Top module: `lcd_ctrl_csr`

## Requirements
- R1: A write at a register's base offset (control at byte 0x00, mode at byte 0x10) replaces all writable bits of that register with the write data.
- R2: A write at base plus 0x4 turns on exactly the writable bits that are one in the data and leaves all other bits unchanged.
- R3: A write at base plus 0x8 turns off exactly the writable bits that are one in the data; a write at base plus 0xC changes nothing.
- R4: After reset the control register reads 0xC000_0000 (soft reset bit 31 and clock gate bit 30 set) and the mode register reads zero.
- R5: While bit 31 of control is set, one clock later every field other than bits 31 and 30 is zero in both registers, bit 30 is forced to one, and writes to those other fields are lost.
- R6: After bit 30 is cleared, it continues to read one for GATE_LAT clocks, then reads zero.
- R7: Control bit 0 reads back the run status: it follows a set of run, and after run is cleared it stays one until fifo_empty_i is high, dropping one clock after that.
- R8: Mode bit 9 (frame-done status) is set by a frame_done_i pulse and cleared only by a one written to it at the clear alias; irq_o is high when bit 9 and the enable at mode bit 13 are both one.
- R9: Mode bit 21 (FIFO clear) reads one, and drives fifo_clear_o, for exactly one clock after it is written as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1 to 2) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, any alias |
| fifo_empty_i | input | 1 | Downstream pixel FIFO is empty |
| frame_done_i | input | 1 | One-clock frame completion pulse |
| run_o | output | 1 | Run status (control bit 0 readback) |
| dotclk_mode_o | output | 1 | Dot-clock mode (control bit 17) |
| fifo_clear_o | output | 1 | FIFO-clear strobe (mode bit 21) |
| soft_rst_o | output | 1 | Soft reset held (control bit 31) |
| clk_gate_o | output | 1 | Clock gate status (control bit 30 readback) |
| irq_o | output | 1 | Frame-done interrupt |

## Verification
A wrong merge of alias data shows on the next read of the register, one clock after the write, as bits that moved although they were not named in the data. A wrong soft-reset override shows as configuration surviving into the clock after bit 31 is seen, or as the gate reading zero during reset. A drain or settle counter that is off shows as run or gate status changing one or more clocks early or late, so those readbacks are sampled at exact clock counts after the triggering write or input change.

// File: rtl/lcd_csr_pkg.sv
package lcd_csr_pkg;

  typedef enum logic [1:0] {
    ALIAS_PLAIN = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_RSVD  = 2'd3
  } alias_e;

  localparam int DW = 32;

  // control register fields
  localparam int SRST_BIT   = 31;
  localparam int GATE_BIT   = 30;
  localparam int DOTCLK_BIT = 17;
  localparam int BUSW_LSB   = 8;
  localparam int RUN_BIT    = 0;

  // mode register fields
  localparam int FIFO_CLR_BIT = 21;
  localparam int PACK_LSB     = 16;
  localparam int FD_EN_BIT    = 13;
  localparam int FD_STS_BIT   = 9;

  localparam int CTRL_IDX = 0;
  localparam int MODE_IDX = 1;

  localparam logic [DW-1:0] CTRL_HS_MASK  = (32'h1 << SRST_BIT) | (32'h1 << GATE_BIT);
  localparam logic [DW-1:0] CTRL_CFG_MASK = (32'h1 << DOTCLK_BIT) | (32'h3 << BUSW_LSB)
                                          | (32'h1 << RUN_BIT);
  localparam logic [DW-1:0] CTRL_RW_MASK  = CTRL_HS_MASK | CTRL_CFG_MASK;
  localparam logic [DW-1:0] MODE_RW_MASK  = (32'h1 << FIFO_CLR_BIT) | (32'hF << PACK_LSB)
                                          | (32'h1 << FD_EN_BIT);
  localparam logic [DW-1:0] MODE_STS_MASK = (32'h1 << FD_STS_BIT);

endpackage

// File: rtl/csr_alias_merge.sv
module csr_alias_merge
  import lcd_csr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         hit,
  input  alias_e       op,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] merged
);

  logic [W-1:0] wsel;

  always_comb begin
    wsel   = wdata & mask;
    merged = old_val;
    if (hit) begin
      case (op)
        ALIAS_PLAIN: merged = (old_val & ~mask) | wsel;
        ALIAS_SET:   merged = old_val | wsel;
        ALIAS_CLR:   merged = old_val & ~wsel;
        default:     merged = old_val;
      endcase
    end
  end

endmodule

// File: rtl/csr_run_drain.sv
module csr_run_drain (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic fifo_empty,
  output logic run_active
);

  logic active_d;
  logic active_q;
  logic active_en;

  always_comb begin
    active_en = run_req | active_q;
    active_d  = run_req | (active_q & ~fifo_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  assign run_active = active_q;

endmodule

// File: rtl/csr_gate_settle.sv
module csr_gate_settle #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_req,
  output logic gate_status
);

  localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  always_comb begin
    cnt_en = gate_req | (cnt_q != '0);
    if (gate_req) begin
      cnt_d = LOAD;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign gate_status = gate_req | (cnt_q != '0);

endmodule

// File: rtl/lcd_ctrl_csr.sv
module lcd_ctrl_csr
  import lcd_csr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int GATE_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              fifo_empty_i,
  input  logic              frame_done_i,
  output logic              run_o,
  output logic              dotclk_mode_o,
  output logic              fifo_clear_o,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic              irq_o
);

  localparam int IDX_W = ADDR_W - 4;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic [IDX_W-1:0] reg_idx;
  alias_e           op;
  logic             ctrl_sel, mode_sel, ctrl_hit, mode_hit;

  assign reg_idx  = bus_addr[ADDR_W-1:4];
  assign op       = alias_e'(bus_addr[3:2]);
  assign ctrl_sel = (reg_idx == IDX_W'(CTRL_IDX));
  assign mode_sel = (reg_idx == IDX_W'(MODE_IDX));
  assign ctrl_hit = bus_wr & ctrl_sel;
  assign mode_hit = bus_wr & mode_sel;

  logic [DW-1:0] ctrl_q, ctrl_d, ctrl_wr;
  logic [DW-1:0] mode_q, mode_d, mode_wr, mode_mask;
  logic          ctrl_en, mode_en, fifo_pulse, srst_q;

  assign srst_q = ctrl_q[SRST_BIT];

  csr_alias_merge #(.W(DW)) ctrl_merge_i (
    .hit     (ctrl_hit),
    .op      (op),
    .old_val (ctrl_q),
    .wdata   (bus_wdata),
    .mask    (CTRL_RW_MASK),
    .merged  (ctrl_wr)
  );

  assign mode_mask = (op == ALIAS_CLR) ? (MODE_RW_MASK | MODE_STS_MASK) : MODE_RW_MASK;

  csr_alias_merge #(.W(DW)) mode_merge_i (
    .hit     (mode_hit),
    .op      (op),
    .old_val (mode_q),
    .wdata   (bus_wdata),
    .mask    (mode_mask),
    .merged  (mode_wr)
  );

  // control next state
  always_comb begin
    ctrl_en = ctrl_hit | srst_q;
    ctrl_d  = ctrl_wr;
    if (srst_q) begin
      ctrl_d = (ctrl_wr & CTRL_HS_MASK) | (32'h1 << GATE_BIT);
    end
  end

  // mode next state
  always_comb begin
    fifo_pulse = mode_hit & ((op == ALIAS_PLAIN) | (op == ALIAS_SET))
               & bus_wdata[FIFO_CLR_BIT];
    mode_en = mode_hit | srst_q | frame_done_i | mode_q[FIFO_CLR_BIT];
    mode_d  = mode_wr;
    mode_d[FIFO_CLR_BIT] = fifo_pulse;
    mode_d[FD_STS_BIT]   = mode_wr[FD_STS_BIT] | frame_done_i;
    if (srst_q) begin
      mode_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTRL_HS_MASK;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  // status trackers
  logic run_active;
  logic gate_status;

  csr_run_drain run_drain_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run_req    (ctrl_q[RUN_BIT]),
    .fifo_empty (fifo_empty_i),
    .run_active (run_active)
  );

  csr_gate_settle #(.LAT(GATE_LAT)) gate_settle_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gate_req    (ctrl_q[GATE_BIT]),
    .gate_status (gate_status)
  );

  // readback
  logic [DW-1:0] ctrl_rd;

  always_comb begin
    ctrl_rd           = ctrl_q;
    ctrl_rd[GATE_BIT] = gate_status;
    ctrl_rd[RUN_BIT]  = run_active;
    if (ctrl_sel) begin
      bus_rdata = ctrl_rd;
    end else if (mode_sel) begin
      bus_rdata = mode_q;
    end else begin
      bus_rdata = '0;
    end
  end

  assign run_o         = run_active;
  assign dotclk_mode_o = ctrl_q[DOTCLK_BIT];
  assign fifo_clear_o  = mode_q[FIFO_CLR_BIT];
  assign soft_rst_o    = srst_q;
  assign clk_gate_o    = gate_status;
  assign irq_o         = mode_q[FD_EN_BIT] & mode_q[FD_STS_BIT];

endmodule

// File: rtl/lcd_ctrl_csr_chk.sv
module lcd_ctrl_csr_chk
  import lcd_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:2] bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              fifo_empty_i,
  input logic              fifo_clear_o,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     mode_q,
  input logic              run_active
);

  localparam int AW = ADDR_W - 2;
  localparam logic [AW-1:0] W_CTRL     = AW'(0);
  localparam logic [AW-1:0] W_CTRL_SET = AW'(1);
  localparam logic [AW-1:0] W_CTRL_CLR = AW'(2);
  localparam logic [AW-1:0] W_MODE_CLR = AW'(6);

  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == W_CTRL && !ctrl_q[SRST_BIT]) |=> ((ctrl_q & CTRL_CFG_MASK) == ($past(bus_wdata) & CTRL_CFG_MASK))); // R1

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == W_CTRL_SET && !ctrl_q[SRST_BIT]) |=> ((ctrl_q & CTRL_CFG_MASK) == (($past(ctrl_q) | $past(bus_wdata)) & CTRL_CFG_MASK))); // R2

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == W_CTRL_CLR && !ctrl_q[SRST_BIT]) |=> ((ctrl_q & CTRL_CFG_MASK) == ($past(ctrl_q) & ~$past(bus_wdata) & CTRL_CFG_MASK))); // R3

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q[SRST_BIT] |=> ((ctrl_q & CTRL_CFG_MASK) == '0 && mode_q == '0)); // R5

  AST_SRST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q[SRST_BIT] |=> ctrl_q[GATE_BIT]); // R5

  AST_RUN_HOLDS_UNTIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_active && !fifo_empty_i) |=> run_active); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[FD_STS_BIT] && !ctrl_q[SRST_BIT] && !(bus_wr && bus_addr == W_MODE_CLR && bus_wdata[FD_STS_BIT]))
      |=> mode_q[FD_STS_BIT]); // R8

  AST_FIFO_CLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_clear_o && !bus_wr) |=> !fifo_clear_o); // R9

endmodule

bind lcd_ctrl_csr lcd_ctrl_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .fifo_empty_i (fifo_empty_i),
  .fifo_clear_o (fifo_clear_o),
  .ctrl_q       (ctrl_q),
  .mode_q       (mode_q),
  .run_active   (run_active)
);

// File: tb/lcd_ctrl_csr_tb_top.sv
`timescale 1ns/1ps
module lcd_ctrl_csr_tb_top;

  localparam int GATE_LAT = 4;
  localparam logic [31:0] CFG_C  = 32'h0002_0301;
  localparam logic [31:0] RW_M   = 32'h002F_2000;
  localparam logic [31:0] STS_M  = 32'h0000_0200;
  localparam logic [7:0] A_CTRL = 8'h00, A_CSET = 8'h04, A_CCLR = 8'h08, A_CRSV = 8'h0C;
  localparam logic [7:0] A_MODE = 8'h10, A_MSET = 8'h14, A_MCLR = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:2]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fifo_empty_i = 1'b1;
  logic        frame_done_i = 1'b0;
  logic        run_o, dotclk_mode_o, fifo_clear_o, soft_rst_o, clk_gate_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_ctrl_csr #(.ADDR_W(8), .GATE_LAT(GATE_LAT)) dut_i (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .fifo_empty_i (fifo_empty_i),
    .frame_done_i (frame_done_i), .run_o (run_o), .dotclk_mode_o (dotclk_mode_o),
    .fifo_clear_o (fifo_clear_o), .soft_rst_o (soft_rst_o), .clk_gate_o (clk_gate_o),
    .irq_o (irq_o)
  );

  function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] wd,
                                        input int op, input logic [31:0] m);
    case (op)
      0:       return (old & ~m) | (wd & m);
      1:       return old | (wd & m);
      2:       return old & ~(wd & m);
      default: return old;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a[7:2];
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[7:2];
    #0.1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, mc, mm;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R4 reset state
    rd(A_CTRL, v); check("R4 ctrl reset", v, 32'hC000_0000);
    rd(A_MODE, v); check("R4 mode reset", v, 32'h0);
    check("R4 outputs", {28'h0, soft_rst_o, clk_gate_o, irq_o, run_o}, {28'h0, 4'b1100});

    // R5 writes lost while soft reset held
    wr(A_CTRL, 32'hC002_0301);
    wr(A_MSET, 32'h000F_2000);
    idle(1);
    rd(A_CTRL, v); check("R5 ctrl held default", v, 32'hC000_0000);
    rd(A_MODE, v); check("R5 mode held default", v, 32'h0);

    // R5/R6 bring-up handshake
    wr(A_CCLR, 32'h8000_0000);
    rd(A_CTRL, v); check("R5 srst cleared gate kept", v, 32'h4000_0000);
    wr(A_CCLR, 32'h4000_0000);
    rd(A_CTRL, v); check("R6 gate just cleared", v[30], 1'b1);
    idle(GATE_LAT - 1);
    rd(A_CTRL, v); check("R6 gate last settle cycle", v[30], 1'b1);
    idle(1);
    rd(A_CTRL, v); check("R6 gate settled", v, 32'h0);
    check("R6 clk_gate_o", clk_gate_o, 1'b0);
    wr(A_CCLR, 32'h8000_0000);

    // R1/R2/R3 directed
    wr(A_CTRL, 32'h0000_0300);
    wr(A_CSET, 32'h0002_0001);
    idle(1);
    rd(A_CTRL, v); check("R2 set alias", v, 32'h0002_0301);
    check("R1 dotclk and run outputs", {dotclk_mode_o, run_o}, 2'b11);
    wr(A_CCLR, 32'h0000_0100);
    idle(1);
    rd(A_CTRL, v); check("R3 clear alias", v, 32'h0002_0201);
    wr(A_CRSV, 32'hFFFF_FFFF);
    idle(1);
    rd(A_CTRL, v); check("R3 reserved alias ignored", v, 32'h0002_0201);

    // R7 run drains
    @(negedge clk); fifo_empty_i = 1'b0;
    wr(A_CCLR, 32'h0000_0001);
    rd(A_CTRL, v); check("R7 run right after clear", v[0], 1'b1);
    idle(5);
    rd(A_CTRL, v); check("R7 run while fifo busy", {v[0], run_o}, 2'b11);
    fifo_empty_i = 1'b1;
    @(negedge clk);
    rd(A_CTRL, v); check("R7 run after drain", {v[0], run_o}, 2'b00);

    // R8 sticky frame done
    @(negedge clk); frame_done_i = 1'b1;
    @(negedge clk); frame_done_i = 1'b0;
    rd(A_MODE, v); check("R8 status set", v, 32'h0000_0200);
    wr(A_MODE, 32'h0);
    rd(A_MODE, v); check("R8 base write keeps status", v, 32'h0000_0200);
    wr(A_MSET, 32'h0000_2000);
    rd(A_MODE, v); check("R8 enable set", v, 32'h0000_2200);
    check("R8 irq high", irq_o, 1'b1);
    wr(A_MCLR, 32'h0000_0200);
    rd(A_MODE, v); check("R8 clear alias clears", v, 32'h0000_2000);
    check("R8 irq low", irq_o, 1'b0);

    // R9 FIFO clear strobe
    wr(A_MSET, 32'h0020_0000);
    rd(A_MODE, v); check("R9 strobe set", {v[21], fifo_clear_o}, 2'b11);
    @(negedge clk);
    rd(A_MODE, v); check("R9 strobe cleared", {v[21], fifo_clear_o}, 2'b00);

    // R1 R2 R3 random
    rd(A_CTRL, mc);
    rd(A_MODE, mm);
    for (int i = 0; i < 60; i++) begin
      int unsigned sel = $urandom % 2;
      int op = int'($urandom % 3);
      logic [31:0] d = $urandom;
      if (sel == 0) begin
        d &= ~32'hC000_0000;
        wr(A_CTRL + 8'(op * 4), d);
        mc = apply(mc, d, op, CFG_C);
      end else begin
        wr(A_MODE + 8'(op * 4), d);
        mm = apply(mm, d, op, (op == 2) ? (RW_M | STS_M) : RW_M);
        mm[21] = 1'b0;
      end
      idle(1);
      rd(A_CTRL, v); check("R1 R2 R3 random ctrl", v, mc);
      rd(A_MODE, v); check("R1 R2 R3 random mode", v, mm);
    end

    // R5 soft reset during operation
    wr(A_CSET, 32'h0002_0301);
    wr(A_MSET, 32'h000F_2000);
    wr(A_CSET, 32'h8000_0000);
    idle(2);
    rd(A_CTRL, v); check("R5 mid-run soft reset ctrl", v, 32'hC000_0000);
    rd(A_MODE, v); check("R5 mid-run soft reset mode", v, 32'h0);
    check("R5 outputs", {soft_rst_o, clk_gate_o, run_o, dotclk_mode_o}, 4'b1100);

    summary();
  end

endmodule